// File: doc/BRIEF.md
# Staggered SDRAM Refresh Sequencer

This block keeps an eight-chip-select SDRAM array refreshed. An interval timer raises a refresh request at a programmable period. When a request is pending, the block takes the command pins away from the main memory controller by dropping its grant. It waits until the controller reports that it is idle, then issues auto-refresh (CBR) commands to one pair of chip selects per clock. The pairs are visited in a fixed order so that no two pairs draw refresh current on the same clock. After the last pair, it holds the grant low for a programmable number of cycles before any bank activate may follow.

The block also follows the power mode. In run, doze and nap modes it refreshes normally. In sleep mode, a configuration input picks one of three behaviours: self-refresh, normal refresh, or no refresh at all. With self-refresh, the block enters with a refresh command issued while CKE goes low. When sleep-with-self-refresh is left, it raises CKE and applies the same recovery wait. The command pins drive deselect (all high) whenever the block is not issuing a command. The system muxes these pins with the controller's pins under the grant.

Top module: `sdram_refresh_seq`

## Requirements
- R1: A refresh request is raised once every `period_i` cycles (0 treated as 1); in run mode with the controller always idle, the first-pair refresh commands of successive sequences are exactly `period_i` cycles apart.
- R2: Every staggered refresh step drives a CBR command (RAS_n, CAS_n low, WE_n high, CKE high) with exactly two chip-select lines low, bit p and bit 7-p of `cs_n_o` for pair p.
- R3: The pairs are refreshed on four consecutive clocks in the order pair 0 = {0,7}, pair 1 = {1,6}, pair 2 = {2,5}, pair 3 = {3,4}.
- R4: `gnt_o` is low from the start of a refresh sequence. It rises exactly `recov_i` cycles after the cycle of the pair-3 command (0 treated as 1).
- R5: Once `gnt_o` has dropped for a pending request, no command is issued while `mc_idle_i` is low. The pair-0 command appears on the cycle after `mc_idle_i` is sampled high.
- R6: With `pwr_mode_i` = 1 (doze) or 2 (nap), refresh proceeds exactly as in run mode (0).
- R7: With `pwr_mode_i` = 3 (sleep) and `sleep_cfg_i` = 0, the block waits for `mc_idle_i`. It then drives one cycle with all eight chip selects low, RAS_n and CAS_n low, WE_n high and CKE low. After that it holds CKE low with deselect on the pins and `gnt_o` low.
- R8: When sleep with self-refresh is left, CKE rises on a cycle with deselect. `gnt_o` rises `recov_i` cycles later (0 treated as 1). Requests raised while in self-refresh are discarded.
- R9: With sleep mode and `sleep_cfg_i` = 1, staggered CBR refresh continues as in run mode.
- R10: With sleep mode and `sleep_cfg_i` = 2 or 3, no command is issued, `gnt_o` stays high, requests are discarded and no overrun is flagged.
- R11: If the timer reaches its terminal count again while an earlier request is still unserviced, `overrun_o` pulses high for one cycle.
- R12: A request raised during the self-refresh exit and recovery is held and serviced right after: `gnt_o` is high for one cycle, and the pair-0 command follows two cycles after `gnt_o` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_mode_i | input | 2 | Power mode: 0 run, 1 doze, 2 nap, 3 sleep |
| sleep_cfg_i | input | 2 | Sleep refresh: 0 self-refresh, 1 normal, 2/3 none |
| period_i | input | PERIOD_W | Refresh interval in cycles |
| recov_i | input | RECOV_W | Refresh-to-activate cycles |
| mc_idle_i | input | 1 | Controller has released the SDRAM pins |
| gnt_o | output | 1 | Controller may use the SDRAM pins |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| overrun_o | output | 1 | One-cycle pulse on a missed refresh interval |

## Verification
The staggered sequence is run under every mode that should refresh: run, doze, nap, and sleep with normal refresh. This shows that the mode decode does not suppress or alter refresh where it must continue. Recovery lengths of 0, 1, 3 and 22 separate correct grant timing from off-by-one counting. The long value also forces a timer request to land inside the exit recovery, which tests that such a request is held. The controller's idle input is held low for a short spell and for a long one. The short spell shows that commands wait for the handshake. The long spell spans two intervals and must raise an overrun. A stretch in sleep with no refresh, and one in self-refresh, each longer than several intervals, show that requests are discarded and not just delayed.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_DOZE  = 2'd1,
        PM_NAP   = 2'd2,
        PM_SLEEP = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        SC_SELF  = 2'd0,
        SC_CBR   = 2'd1,
        SC_OFF   = 2'd2,
        SC_OFF_B = 2'd3
    } slpcfg_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DRAIN    = 3'd1,
        ST_STEP     = 3'd2,
        ST_RECOV    = 3'd3,
        ST_DRAIN_SR = 3'd4,
        ST_SR_ENTER = 3'd5,
        ST_SELF     = 3'd6,
        ST_SR_EXIT  = 3'd7
    } seq_st_e;

endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                take_i,
    input  logic                drop_i,
    output logic                pend_o,
    output logic                ovr_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                pend;
        logic                ovr;
    } tmr_t;

    tmr_t q, d;
    logic [PERIOD_W-1:0] lim;
    logic                tick;

    always_comb begin
        d    = q;
        lim  = (period_i == '0) ? '0 : period_i - 1'b1;
        tick = (q.cnt >= lim);
        d.cnt  = tick ? '0 : q.cnt + 1'b1;
        d.pend = (q.pend & ~take_i & ~drop_i) | (tick & ~drop_i);
        d.ovr  = tick & q.pend & ~take_i & ~drop_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;
    assign ovr_o  = q.ovr;

    assert_overrun_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> $past(q.pend));

    assert_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> !q.pend);

endmodule

// File: rtl/ref_stagger.sv
module ref_stagger #(
    parameter int NUM_CS = 8,
    parameter int IDX_W  = 2
) (
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NUM_CS-1:0] sel_o
);
    localparam int NUM_PAIRS = NUM_CS / 2;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        localparam int PAIR = (i < NUM_PAIRS) ? i : (NUM_CS - 1 - i);
        assign sel_o[i] = en_i && (idx_i == IDX_W'(PAIR));
    end

endmodule

// File: rtl/ref_ctrl.sv
module ref_ctrl
    import refseq_pkg::*;
#(
    parameter int RECOV_W   = 8,
    parameter int NUM_PAIRS = 4,
    parameter int IDX_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pmode_e             mode_i,
    input  slpcfg_e            cfg_i,
    input  logic               mc_idle_i,
    input  logic               pend_i,
    input  logic [RECOV_W-1:0] recov_i,
    output logic               take_o,
    output logic               drop_o,
    output logic               gnt_o,
    output logic               step_en_o,
    output logic [IDX_W-1:0]   step_idx_o,
    output logic               all_cs_o,
    output logic               cmd_o,
    output logic               cke_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PAIRS - 1);

    typedef struct packed {
        seq_st_e            st;
        logic [IDX_W-1:0]   idx;
        logic [RECOV_W-1:0] cnt;
    } ctl_t;

    ctl_t q, d;
    logic want_sr, no_ref;

    always_comb begin
        d       = q;
        take_o  = 1'b0;
        drop_o  = 1'b0;
        want_sr = (mode_i == PM_SLEEP) && (cfg_i == SC_SELF);
        no_ref  = (mode_i == PM_SLEEP) && ((cfg_i == SC_OFF) || (cfg_i == SC_OFF_B));
        case (q.st)
            ST_IDLE: begin
                if (want_sr) begin
                    d.st   = ST_DRAIN_SR;
                    drop_o = 1'b1;
                end else if (no_ref) begin
                    drop_o = 1'b1;
                end else if (pend_i) begin
                    take_o = 1'b1;
                    d.st   = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (mc_idle_i) begin
                    d.st  = ST_STEP;
                    d.idx = '0;
                end
            end
            ST_STEP: begin
                if (q.idx == LAST) begin
                    if (recov_i <= RECOV_W'(1)) d.st = ST_IDLE;
                    else begin
                        d.st  = ST_RECOV;
                        d.cnt = recov_i - RECOV_W'(2);
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_RECOV: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_DRAIN_SR: begin
                drop_o = 1'b1;
                if (mc_idle_i) d.st = ST_SR_ENTER;
            end
            ST_SR_ENTER: begin
                drop_o = 1'b1;
                d.st   = ST_SELF;
            end
            ST_SELF: begin
                drop_o = 1'b1;
                if (!want_sr) d.st = ST_SR_EXIT;
            end
            ST_SR_EXIT: begin
                if (recov_i <= RECOV_W'(1)) d.st = ST_IDLE;
                else begin
                    d.st  = ST_RECOV;
                    d.cnt = recov_i - RECOV_W'(2);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.idx <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign gnt_o      = (q.st == ST_IDLE);
    assign step_en_o  = (q.st == ST_STEP);
    assign step_idx_o = q.idx;
    assign all_cs_o   = (q.st == ST_SR_ENTER);
    assign cmd_o      = step_en_o | all_cs_o;
    assign cke_o      = !((q.st == ST_SR_ENTER) || (q.st == ST_SELF));

    assert_stagger_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STEP && q.idx != '0) |-> ($past(q.st) == ST_STEP && $past(q.idx) == q.idx - 1'b1));

    assert_step_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STEP && q.idx == '0) |-> ($past(q.st) == ST_DRAIN && $past(mc_idle_i)));

    assert_sr_exit_only_when_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SR_EXIT) |-> ($past(q.st) == ST_SELF));

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import refseq_pkg::*;
#(
    parameter int NUM_CS   = 8,
    parameter int PERIOD_W = 16,
    parameter int RECOV_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          pwr_mode_i,
    input  logic [1:0]          sleep_cfg_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [RECOV_W-1:0]  recov_i,
    input  logic                mc_idle_i,
    output logic                gnt_o,
    output logic [NUM_CS-1:0]   cs_n_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                we_n_o,
    output logic                cke_o,
    output logic                overrun_o
);
    localparam int NUM_PAIRS = NUM_CS / 2;
    localparam int IDX_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

    logic             pend, take, drop;
    logic             step_en, all_cs, cmd;
    logic [IDX_W-1:0] step_idx;
    logic [NUM_CS-1:0] pair_sel;

    ref_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .take_i   (take),
        .drop_i   (drop),
        .pend_o   (pend),
        .ovr_o    (overrun_o)
    );

    ref_ctrl #(.RECOV_W(RECOV_W), .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (pmode_e'(pwr_mode_i)),
        .cfg_i      (slpcfg_e'(sleep_cfg_i)),
        .mc_idle_i  (mc_idle_i),
        .pend_i     (pend),
        .recov_i    (recov_i),
        .take_o     (take),
        .drop_o     (drop),
        .gnt_o      (gnt_o),
        .step_en_o  (step_en),
        .step_idx_o (step_idx),
        .all_cs_o   (all_cs),
        .cmd_o      (cmd),
        .cke_o      (cke_o)
    );

    ref_stagger #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_stagger (
        .en_i  (step_en),
        .idx_i (step_idx),
        .sel_o (pair_sel)
    );

    assign cs_n_o  = ~(pair_sel | {NUM_CS{all_cs}});
    assign ras_n_o = ~cmd;
    assign cas_n_o = ~cmd;
    assign we_n_o  = 1'b1;

    assert_pair_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && cke_o) |-> ($countones(~cs_n_o) == 2));

    assert_no_cmd_with_gnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o) |-> !gnt_o);

    assert_sr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> (cs_n_o == '0 && !ras_n_o && !cas_n_o && we_n_o));

    assert_sr_no_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> !gnt_o);

    assert_cke_rise_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (cs_n_o == '1 && ras_n_o));

endmodule

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pwr_mode = 2'd0;
    logic [1:0]  sleep_cfg = 2'd0;
    logic [15:0] period = 16'd20;
    logic [7:0]  recov = 8'd3;
    logic        mc_idle = 1'b1;
    logic        gnt, ras_n, cas_n, we_n, cke, overrun;
    logic [7:0]  cs_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ovr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;

    sdram_refresh_seq dut (
        .clk(clk), .rst_n(rst_n), .pwr_mode_i(pwr_mode), .sleep_cfg_i(sleep_cfg),
        .period_i(period), .recov_i(recov), .mc_idle_i(mc_idle), .gnt_o(gnt),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .cke_o(cke), .overrun_o(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pair_mask(input int p);
        return 8'(1 << p) | 8'(1 << (7 - p));
    endfunction

    // waits for the pair-0 command, checks all four steps, returns its cycle
    task automatic run_stagger(input string req, output int start);
        int n = 0;
        start = -1;
        while (!(cs_n != 8'hFF && cke) && n < 200) begin
            @(negedge clk); n++;
        end
        chk(n < 200, req, "sequence start seen", n, 0);
        start = cyc;
        for (int p = 0; p < 4; p++) begin
            chk(cs_n == ~pair_mask(p), req, $sformatf("pair %0d cs_n", p), cs_n, ~pair_mask(p));
            chk(!ras_n && !cas_n && we_n && cke && !gnt, req, "CBR encoding",
                {ras_n, cas_n, we_n, cke, gnt}, 5'b00110);
            if (p < 3) @(negedge clk);
        end
    endtask

    // from a reference negedge, grant low for eff-1 cycles then high
    task automatic check_recov(input int r, input string req);
        int eff = (r == 0) ? 1 : r;
        for (int k = 1; k < eff; k++) begin
            @(negedge clk);
            chk(!gnt, req, $sformatf("gnt low at +%0d", k), gnt, 0);
        end
        @(negedge clk);
        chk(gnt, req, $sformatf("gnt high at +%0d", eff), gnt, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(gnt && cs_n == 8'hFF && ras_n && cas_n && we_n && cke && !overrun, "R4",
            "reset state", {gnt, cs_n, ras_n, cas_n, we_n, cke, overrun}, 14'h3FFE);
        rst_n = 1'b1;
    endtask

    task automatic t_run;
        int s1, s2, o0;
        o0 = ovr_cnt;
        recov = 8'd3;
        run_stagger("R2 R3", s1);
        check_recov(3, "R4");
        run_stagger("R2 R3", s2);
        check_recov(3, "R4");
        chk(s2 - s1 == 20, "R1", "interval between sequences", s2 - s1, 20);
        chk(ovr_cnt == o0, "R11", "no overrun in normal run", ovr_cnt - o0, 0);
    endtask

    task automatic t_recov_edges;
        int s;
        recov = 8'd1;
        run_stagger("R4", s);
        check_recov(1, "R4");
        recov = 8'd0;
        run_stagger("R4", s);
        check_recov(0, "R4");
        recov = 8'd3;
    endtask

    task automatic t_handshake;
        int n = 0;
        @(negedge clk);
        mc_idle = 1'b0;
        while (gnt && n < 100) begin @(negedge clk); n++; end
        chk(!gnt, "R5", "grant dropped for request", gnt, 0);
        for (int k = 0; k < 5; k++) begin
            chk(cs_n == 8'hFF && ras_n, "R5", "no command while busy", cs_n, 8'hFF);
            @(negedge clk);
        end
        mc_idle = 1'b1;
        @(negedge clk);
        chk(cs_n == ~pair_mask(0), "R5", "pair 0 after idle", cs_n, ~pair_mask(0));
        repeat (10) @(negedge clk);
    endtask

    task automatic t_overrun;
        int o0;
        @(negedge clk);
        o0 = ovr_cnt;
        mc_idle = 1'b0;
        repeat (60) @(negedge clk);
        chk(ovr_cnt > o0, "R11", "overrun flagged", ovr_cnt - o0, 1);
        mc_idle = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_doze_nap;
        int s;
        @(negedge clk); pwr_mode = 2'd1;
        run_stagger("R6 doze", s);
        check_recov(3, "R6");
        @(negedge clk); pwr_mode = 2'd2;
        run_stagger("R6 nap", s);
        check_recov(3, "R6");
        @(negedge clk); pwr_mode = 2'd0;
    endtask

    task automatic t_sleep_cbr;
        int s;
        @(negedge clk); pwr_mode = 2'd3; sleep_cfg = 2'd1;
        run_stagger("R9", s);
        check_recov(3, "R9");
        @(negedge clk); pwr_mode = 2'd0;
    endtask

    task automatic t_sleep_off;
        int o0;
        bit quiet = 1;
        @(negedge clk); pwr_mode = 2'd3; sleep_cfg = 2'd2;
        repeat (15) @(negedge clk);
        o0 = ovr_cnt;
        for (int k = 0; k < 70; k++) begin
            if (k == 35) sleep_cfg = 2'd3;
            if (cs_n != 8'hFF || !ras_n || !gnt) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R10", "no command and grant kept", quiet, 1);
        chk(ovr_cnt == o0, "R10", "no overrun without refresh", ovr_cnt - o0, 0);
        pwr_mode = 2'd0; sleep_cfg = 2'd0;
    endtask

    task automatic enter_self(input string req);
        int n = 0;
        bit held = 1;
        @(negedge clk); pwr_mode = 2'd3; sleep_cfg = 2'd0;
        while (cke && n < 60) begin @(negedge clk); n++; end
        chk(cs_n == 8'h00 && !ras_n && !cas_n && we_n && !cke, req, "self-refresh entry",
            {cs_n, ras_n, cas_n, we_n, cke}, 12'h002);
        @(negedge clk);
        for (int k = 0; k < 60; k++) begin
            if (cke || cs_n != 8'hFF || !ras_n || gnt) held = 0;
            @(negedge clk);
        end
        chk(held, req, "held in self-refresh, requests discarded", held, 1);
    endtask

    task automatic t_self;
        enter_self("R7");
        recov = 8'd3;
        pwr_mode = 2'd0;
        @(negedge clk);
        chk(cke && cs_n == 8'hFF && ras_n && !gnt, "R8", "exit cke high with deselect",
            {cke, cs_n, ras_n, gnt}, 11'h7FE);
        check_recov(3, "R8");
        repeat (30) @(negedge clk);
    endtask

    task automatic t_exit_pending;
        enter_self("R7");
        recov = 8'd22;
        pwr_mode = 2'd0;
        @(negedge clk);
        chk(cke, "R8", "cke raised on exit", cke, 1);
        check_recov(22, "R12");
        @(negedge clk);
        chk(!gnt, "R12", "held request takes bus", gnt, 0);
        @(negedge clk);
        chk(cs_n == ~pair_mask(0), "R12", "held request serviced", cs_n, ~pair_mask(0));
        recov = 8'd3;
        repeat (30) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_run();
        t_recov_edges();
        t_handshake();
        t_overrun();
        t_doze_nap();
        t_sleep_cbr();
        t_sleep_off();
        t_self();
        t_exit_pending();
        finish_up();
    end

endmodule